// File: doc/BRIEF.md
# Shared-Source Interrupt Node Controller

This block collects peripheral event sources into a small number of interrupt nodes and offers the CPU one prioritised request. Each node serves a fixed group of sources: source `s` belongs to node `s / SRC_PER_NODE`. Every source has a status flag that an event sets and software clears with a write-one-to-clear strobe. Each node has its own enable bit and a pending latch. A single global enable gates delivery to the CPU for all nodes.

The pending latch is kept apart from the flags. It is set by a new flag-set event, which is seen per source on the 0-to-1 transition of that source's flag. It is set only while the node is enabled. It is cleared only by an accepted acknowledge or by disabling the node. Because of this, an event that arrives while another flag of the same node is still set is not lost. A pending node whose flags were already cleared by software still gets serviced once more. That extra service finds no flag and is accepted behaviour.

The CPU side is a request, a vector index and an acknowledge. The lowest pending node index wins. A presented vector is held until it is acknowledged.

Top module: `intn_ctrl`

## Requirements
- R1: A `src_event` pulse on source s sets `flags[s]` at the next clock edge, whatever the node and global enables are. A set and a clear of the same flag in one cycle leave the flag set.
- R2: With `flag_clr_we` high, each source whose bit in `flag_clr_mask` is 1 has its flag cleared at the next edge. Other flags are unchanged.
- R3: A node's pending bit is set at the edge that ends a cycle in which one of its sources has an event while that source's flag is 0, provided `node_en[n]` was already 1 during that cycle. An event seen while the node is disabled sets the flag but records nothing, and a later enable raises no request for it.
- R4: Writing 0 to a node's enable bit (`node_en_we` high, bit n of `node_en_wdata` low) clears that node's pending bit at the same edge.
- R5: Clearing source flags never clears a pending bit. A node stays pending, and keeps requesting, after all its flags are cleared.
- R6: An event on a source whose flag is 0 sets the node's pending bit even when another flag of the same node is still 1. A repeated event on a source whose flag is already 1 sets nothing.
- R7: While `glb_en` is 0, `irq_req` is 0, but enabled nodes still capture pending bits. Once `glb_en` becomes 1, those pending nodes are requested.
- R8: `irq_req` equals `glb_en` AND (any pending bit). When no vector is being held, `irq_vec` is the lowest pending node index.
- R9: Once `irq_req` presents node k, `irq_vec` stays k in later cycles for as long as node k stays pending and `glb_en` stays 1. This holds even if a lower index becomes pending.
- R10: An acknowledge is accepted when `irq_ack` is high, `irq_req` is high and `ack_vec` equals `irq_vec`. It clears that node's pending bit at the edge, unless the node captures a new event in the same cycle. An acknowledge with a different `ack_vec`, or with no request, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_event | input | N_NODES*SRC_PER_NODE | One-cycle event pulse per source |
| flag_clr_we | input | 1 | Strobe to clear the flags selected by the mask |
| flag_clr_mask | input | N_NODES*SRC_PER_NODE | Flags to clear, one bit per source |
| node_en_we | input | 1 | Strobe to write the node enables |
| node_en_wdata | input | N_NODES | New node enable values |
| glb_en_we | input | 1 | Strobe to write the global enable |
| glb_en_wdata | input | 1 | New global enable value |
| irq_ack | input | 1 | Acknowledge pulse from the CPU |
| ack_vec | input | $clog2(N_NODES) | Node index being acknowledged |
| flags | output | N_NODES*SRC_PER_NODE | Source status flags |
| node_en | output | N_NODES | Current node enables |
| glb_en | output | 1 | Current global enable |
| pend | output | N_NODES | Pending latches |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | $clog2(N_NODES) | Presented node index |

## Verification
Flags, enables and pending bits take one edge to change: a stimulus driven in cycle t shows at those outputs after the edge that ends cycle t. `irq_req` and `irq_vec` follow the pending bits in the same cycle through logic alone, so they also change after that one edge. Holding a vector adds a registered lock, and that lock is visible from the second cycle of a request onward. The bench drives inputs on the falling edge, updates its reference model just after the rising edge, and samples every output on the next falling edge. Each comparison therefore sees exactly one edge's worth of change.

// File: rtl/intn_pkg.sv
package intn_pkg;
  localparam int unsigned DEF_NODES   = 4;
  localparam int unsigned DEF_PER_NODE = 2;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/intn_src_flags.sv
module intn_src_flags #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            clr_we_i,
  input  logic [NSRC-1:0] clr_mask_i,
  output logic [NSRC-1:0] flags_o,
  output logic [NSRC-1:0] rise_o
);
  logic [NSRC-1:0] flag_q, flag_d;
  logic            flag_ce;

  always_comb begin
    flag_d = flag_q;
    if (clr_we_i) flag_d = flag_d & ~clr_mask_i;
    flag_d  = flag_d | evt_i;
    flag_ce = clr_we_i | (|evt_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign rise_o  = evt_i & ~flag_q;
  assign flags_o = flag_q;
endmodule

// File: rtl/intn_node_latch.sv
module intn_node_latch #(
  parameter int unsigned SPN = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SPN-1:0] rise_i,
  input  logic           en_we_i,
  input  logic           en_wbit_i,
  input  logic           ack_clr_i,
  output logic           en_o,
  output logic           pend_o
);
  logic en_q, en_d, pend_q, pend_d, capture;

  always_comb begin
    en_d    = en_we_i ? en_wbit_i : en_q;
    capture = en_q & (|rise_i);
    pend_d  = en_d & ((pend_q & ~ack_clr_i) | capture);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (en_we_i) en_q <= en_d;
      pend_q <= pend_d;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/intn_prio_arb.sv
module intn_prio_arb #(
  parameter int unsigned N  = 4,
  parameter int unsigned VW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend_i,
  input  logic          glb_en_i,
  input  logic          ack_i,
  input  logic [VW-1:0] ack_vec_i,
  output logic          req_o,
  output logic [VW-1:0] vec_o,
  output logic          ack_ok_o
);
  logic          lock_q, lock_d;
  logic [VW-1:0] lock_vec_q;
  logic [VW-1:0] low_idx;
  logic          hold;

  always_comb begin
    low_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) low_idx = VW'(i);
    end
  end

  always_comb begin
    req_o    = glb_en_i & (|pend_i);
    hold     = lock_q & glb_en_i & pend_i[lock_vec_q];
    vec_o    = hold ? lock_vec_q : low_idx;
    ack_ok_o = ack_i & req_o & (ack_vec_i == vec_o);
    lock_d   = req_o & ~ack_ok_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_vec_q <= '0;
    end else begin
      lock_q <= lock_d;
      if (req_o) lock_vec_q <= vec_o;
    end
  end
endmodule

// File: rtl/intn_ctrl.sv
module intn_ctrl
  import intn_pkg::*;
#(
  parameter int unsigned N_NODES      = DEF_NODES,
  parameter int unsigned SRC_PER_NODE = DEF_PER_NODE,
  localparam int unsigned NSRC = N_NODES * SRC_PER_NODE,
  localparam int unsigned VW   = idx_width(N_NODES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    src_event,
  input  logic               flag_clr_we,
  input  logic [NSRC-1:0]    flag_clr_mask,
  input  logic               node_en_we,
  input  logic [N_NODES-1:0] node_en_wdata,
  input  logic               glb_en_we,
  input  logic               glb_en_wdata,
  input  logic               irq_ack,
  input  logic [VW-1:0]      ack_vec,
  output logic [NSRC-1:0]    flags,
  output logic [N_NODES-1:0] node_en,
  output logic               glb_en,
  output logic [N_NODES-1:0] pend,
  output logic               irq_req,
  output logic [VW-1:0]      irq_vec
);
  logic [NSRC-1:0] rise;
  logic            ack_ok;
  logic            glb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         glb_q <= 1'b0;
    else if (glb_en_we) glb_q <= glb_en_wdata;
  end
  assign glb_en = glb_q;

  intn_src_flags #(.NSRC(NSRC)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (src_event),
    .clr_we_i   (flag_clr_we),
    .clr_mask_i (flag_clr_mask),
    .flags_o    (flags),
    .rise_o     (rise)
  );

  for (genvar n = 0; n < N_NODES; n++) begin : g_node
    intn_node_latch #(.SPN(SRC_PER_NODE)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_i    (rise[n*SRC_PER_NODE +: SRC_PER_NODE]),
      .en_we_i   (node_en_we),
      .en_wbit_i (node_en_wdata[n]),
      .ack_clr_i (ack_ok && (irq_vec == VW'(n))),
      .en_o      (node_en[n]),
      .pend_o    (pend[n])
    );
  end

  intn_prio_arb #(.N(N_NODES), .VW(VW)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_i    (pend),
    .glb_en_i  (glb_q),
    .ack_i     (irq_ack),
    .ack_vec_i (ack_vec),
    .req_o     (irq_req),
    .vec_o     (irq_vec),
    .ack_ok_o  (ack_ok)
  );
endmodule

// File: rtl/intn_ctrl_chk.sv
module intn_ctrl_chk #(
  parameter int unsigned N_NODES = 4,
  parameter int unsigned NSRC    = 8,
  parameter int unsigned VW      = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NSRC-1:0]    src_event,
  input logic               node_en_we,
  input logic               glb_en_we,
  input logic               irq_ack,
  input logic [VW-1:0]      ack_vec,
  input logic [NSRC-1:0]    flags,
  input logic [N_NODES-1:0] node_en,
  input logic               glb_en,
  input logic [N_NODES-1:0] pend,
  input logic               irq_req,
  input logic [VW-1:0]      irq_vec
);
  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_event) |=> ((flags & $past(src_event)) == $past(src_event))); // R1

  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~node_en) == '0)); // R4

  AST_GLB_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !irq_req); // R7

  AST_REQ_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> pend[irq_vec]); // R8

  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !(irq_ack && ack_vec == irq_vec) && !node_en_we && !glb_en_we)
    |=> (irq_req && irq_vec == $past(irq_vec))); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && ack_vec == irq_vec && src_event == '0)
    |=> !pend[$past(irq_vec)]); // R10
endmodule

bind intn_ctrl intn_ctrl_chk #(.N_NODES(N_NODES), .NSRC(NSRC), .VW(VW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_event  (src_event),
  .node_en_we (node_en_we),
  .glb_en_we  (glb_en_we),
  .irq_ack    (irq_ack),
  .ack_vec    (ack_vec),
  .flags      (flags),
  .node_en    (node_en),
  .glb_en     (glb_en),
  .pend       (pend),
  .irq_req    (irq_req),
  .irq_vec    (irq_vec)
);

// File: tb/intn_ctrl_bench.sv
module intn_ctrl_bench;
  localparam int N   = 4;
  localparam int SPN = 2;
  localparam int NS  = N * SPN;
  localparam int VW  = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_event;
  logic          flag_clr_we;
  logic [NS-1:0] flag_clr_mask;
  logic          node_en_we;
  logic [N-1:0]  node_en_wdata;
  logic          glb_en_we;
  logic          glb_en_wdata;
  logic          irq_ack;
  logic [VW-1:0] ack_vec;
  logic [NS-1:0] flags;
  logic [N-1:0]  node_en;
  logic          glb_en;
  logic [N-1:0]  pend;
  logic          irq_req;
  logic [VW-1:0] irq_vec;

  always #10 clk = ~clk;

  intn_ctrl #(.N_NODES(N), .SRC_PER_NODE(SPN)) u_intn_ctrl (
    .clk(clk), .rst_n(rst_n), .src_event(src_event), .flag_clr_we(flag_clr_we),
    .flag_clr_mask(flag_clr_mask), .node_en_we(node_en_we), .node_en_wdata(node_en_wdata),
    .glb_en_we(glb_en_we), .glb_en_wdata(glb_en_wdata), .irq_ack(irq_ack), .ack_vec(ack_vec),
    .flags(flags), .node_en(node_en), .glb_en(glb_en), .pend(pend),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  int total = 0;
  int bad   = 0;
  int ticks = 0;

  // reference state
  logic [NS-1:0] m_flags;
  logic [N-1:0]  m_en, m_pend;
  logic          m_glb, m_lock;
  logic [VW-1:0] m_lvec;

  function automatic logic [VW-1:0] lowest(input logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return VW'(i);
    return '0;
  endfunction

  function automatic logic exp_req();
    return m_glb && (|m_pend);
  endfunction

  function automatic logic [VW-1:0] exp_vec();
    if (m_lock && m_glb && m_pend[m_lvec]) return m_lvec;
    return lowest(m_pend);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic          acc;
    logic [NS-1:0] rise;
    logic [N-1:0]  en_d;
    logic [VW-1:0] v;
    logic          r;
    r    = exp_req();
    v    = exp_vec();
    acc  = irq_ack && r && (ack_vec == v);
    rise = src_event & ~m_flags;
    en_d = node_en_we ? node_en_wdata : m_en;
    for (int n = 0; n < N; n++) begin
      logic cap;
      cap = m_en[n] && (|rise[n*SPN +: SPN]);
      m_pend[n] = en_d[n] && ((m_pend[n] && !(acc && v == VW'(n))) || cap);
    end
    m_en   = en_d;
    m_lock = r && !acc;
    if (r) m_lvec = v;
    if (flag_clr_we) m_flags = m_flags & ~flag_clr_mask;
    m_flags = m_flags | src_event;
    if (glb_en_we) m_glb = glb_en_wdata;
  endtask

  task automatic compare_all();
    chk("R1/R2 flags", int'(flags), int'(m_flags));
    chk("R3/R4 pend", int'(pend), int'(m_pend));
    chk("R4 node_en", int'(node_en), int'(m_en));
    chk("R7 glb_en", int'(glb_en), int'(m_glb));
    chk("R8 irq_req", int'(irq_req), int'(exp_req()));
    if (exp_req()) chk("R9 irq_vec", int'(irq_vec), int'(exp_vec()));
  endtask

  task automatic idle();
    src_event = '0; flag_clr_we = 1'b0; flag_clr_mask = '0;
    node_en_we = 1'b0; glb_en_we = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<150000", ticks);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    idle();
    node_en_wdata = '0; glb_en_wdata = 1'b0; ack_vec = '0;
    rst_n = 1'b0;
    m_flags = '0; m_en = '0; m_pend = '0; m_glb = 1'b0; m_lock = 1'b0; m_lvec = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R8 reset irq_req", int'(irq_req), 0);
    chk("R1 reset flags", int'(flags), 0);
    chk("R3 reset pend", int'(pend), 0);

    // enable node0 and global, event on source 0
    node_en_we = 1; node_en_wdata = 4'b0001; glb_en_we = 1; glb_en_wdata = 1; cyc();
    src_event = 8'h01; cyc();
    chk("R1 flag set", int'(flags[0]), 1);
    chk("R3 pend captured", int'(pend[0]), 1);
    chk("R8 vec node0", int'(irq_vec), 0);

    // wrong ack has no effect, right ack clears
    irq_ack = 1; ack_vec = 2'd3; cyc();
    chk("R10 wrong ack ignored", int'(pend[0]), 1);
    irq_ack = 1; ack_vec = 2'd0; cyc();
    chk("R10 ack clears pend", int'(pend[0]), 0);
    chk("R5 flag survives ack", int'(flags[0]), 1);

    // repeat event on set flag: nothing; other source of same node: captured
    src_event = 8'h01; cyc();
    chk("R6 repeat event ignored", int'(pend[0]), 0);
    src_event = 8'h02; cyc();
    chk("R6 sibling event captured", int'(pend[0]), 1);

    // clear flags: pend stays (dummy service)
    flag_clr_we = 1; flag_clr_mask = 8'h03; cyc();
    chk("R2 flags cleared", int'(flags[1:0]), 0);
    chk("R5 pend stays after clear", int'(irq_req), 1);

    // set wins over clear
    src_event = 8'h04; flag_clr_we = 1; flag_clr_mask = 8'h04; cyc();
    chk("R1 set wins over clear", int'(flags[2]), 1);

    // disable node0 clears pend
    node_en_we = 1; node_en_wdata = 4'b0000; cyc();
    chk("R4 disable clears pend", int'(pend[0]), 0);

    // event while disabled, then enable: no request
    src_event = 8'h10; cyc();
    chk("R3 disabled event flag", int'(flags[4]), 1);
    node_en_we = 1; node_en_wdata = 4'b0100; cyc();
    cyc();
    chk("R3 late enable no request", int'(irq_req), 0);

    // global off still captures
    glb_en_we = 1; glb_en_wdata = 0; cyc();
    flag_clr_we = 1; flag_clr_mask = 8'hFF; cyc();
    src_event = 8'h20; cyc();
    chk("R7 captured while off", int'(pend[2]), 1);
    chk("R7 no req while off", int'(irq_req), 0);
    glb_en_we = 1; glb_en_wdata = 1; cyc();
    chk("R7 req after on", int'(irq_req), 1);
    cyc();

    // vector hold while lower index becomes pending
    node_en_we = 1; node_en_wdata = 4'b0110; cyc();
    src_event = 8'h04; cyc();
    chk("R9 vec held", int'(irq_vec), 2);
    irq_ack = 1; ack_vec = 2'd2; cyc();
    chk("R8 next lowest", int'(irq_vec), 1);

    // constrained random phase
    seed = $urandom(32'h5eed);
    for (int k = 0; k < 4000; k++) begin
      src_event = NS'($urandom() & $urandom());
      flag_clr_we = ($urandom_range(0, 3) == 0);
      flag_clr_mask = NS'($urandom());
      node_en_we = ($urandom_range(0, 15) == 0);
      node_en_wdata = N'($urandom());
      glb_en_we = ($urandom_range(0, 31) == 0);
      glb_en_wdata = ($urandom_range(0, 3) != 0);
      irq_ack = ($urandom_range(0, 2) == 0);
      ack_vec = ($urandom_range(0, 4) == 0) ? VW'($urandom()) : exp_vec();
      cyc();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule